// File: doc/BRIEF.md
# Programmable frame sync generator

This block builds a periodic frame-sync waveform (the word-select or left/right clock of a serial audio link) from one of several bit-clock sources. Each source is presented as a one-cycle tick strobe in the block's own clock domain, so all logic runs on a single clock. Software picks a source, sets the high-phase and low-phase lengths in bit clocks, and turns the generator on. The sync output and a frame-start strobe then drive the downstream serializers.

Each phase register holds its length minus one. For a frame of R bit clocks the usual setting is a high value of R/2-1 and a low value of (R+1)/2-1, so an odd frame gets a low phase one clock longer than its high phase. The generator always starts on a high phase, loads a new phase length only at a phase boundary, and holds its output low while it is disabled or has no source selected.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset, fsync and frame_start are 0 and all four registers read 0.
- R2: Registers are at word addresses 0 (control, bit 0 = enable), 1 (source select, bits 3:0), 2 (high length minus one, CNT_W bits) and 3 (low length minus one, CNT_W bits); each reads back what was written, and bits outside the field read 0.
- R3: While running, every high phase lasts HI+1 ticks of the selected source and every low phase lasts LO+1 ticks, HI and LO being the register values in force when that phase began.
- R4: With enable set and a valid source, fsync stays low until the first selected tick, and that tick raises fsync (visible after the clock edge that samples it), starting a high phase.
- R5: frame_start is high for exactly one cycle, in the cycle in which fsync rises, and at no other time.
- R6: A select value of n+1 makes source n the only one that advances the generator; ticks on the other sources have no effect on fsync.
- R7: A select value of 0, or one above NUM_SRC, selects no source: fsync and frame_start stay 0 whatever ticks arrive.
- R8: Clearing the enable bit drives fsync low by the second clock edge after the write; enabling again restarts with a full high phase.
- R9: A phase-length write while running does not change the phase in progress; it applies from the next phase of that kind.
- R10: Ticks that arrive while enable is clear have no effect: fsync stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | NUM_SRC | One-cycle bit-clock tick per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | DATA_W | Register read data (combinational) |
| fsync | output | 1 | Frame sync output |
| frame_start | output | 1 | One-cycle strobe on each rising edge of fsync |

## Verification
The hardest situation to reach is a phase-length write that lands in the middle of a running phase, since only the boundary following it should see the new value. The bench mixes random writes to both length registers into long runs with random tick density and noise on unselected sources, and keeps its own record of which length was in force when each phase began, so every measured phase is compared with the value latched at its start. A directed run with ticks on every cycle and one-tick phases exercises back-to-back boundaries, and separate runs cover disable in mid-phase and out-of-range selects.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   localparam int ADDR_W = 2;
   localparam int SEL_W  = 4;

   typedef enum logic [ADDR_W-1:0] {
      FSG_CTRL = 2'd0,
      FSG_SEL  = 2'd1,
      FSG_HI   = 2'd2,
      FSG_LO   = 2'd3
   } fsg_reg_e;
endpackage

// File: rtl/fsg_regs.sv
module fsg_regs
   import fsg_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int CNT_W  = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic                ctl_en,
   output logic [SEL_W-1:0]    ctl_sel,
   output logic [CNT_W-1:0]    hi_len,
   output logic [CNT_W-1:0]    lo_len
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en  <= 1'b0;
         ctl_sel <= '0;
         hi_len  <= '0;
         lo_len  <= '0;
      end else if (wr_en) begin
         case (fsg_reg_e'(wr_addr))
            FSG_CTRL: ctl_en  <= wr_data[0];
            FSG_SEL:  ctl_sel <= wr_data[SEL_W-1:0];
            FSG_HI:   hi_len  <= wr_data[CNT_W-1:0];
            FSG_LO:   lo_len  <= wr_data[CNT_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (fsg_reg_e'(rd_addr))
         FSG_CTRL: rd_data[0]          = ctl_en;
         FSG_SEL:  rd_data[SEL_W-1:0]  = ctl_sel;
         FSG_HI:   rd_data[CNT_W-1:0]  = hi_len;
         FSG_LO:   rd_data[CNT_W-1:0]  = lo_len;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/fsg_src_mux.sv
module fsg_src_mux
   import fsg_pkg::*;
#(
   parameter int NUM_SRC = 4
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [NUM_SRC-1:0] tick,
   output logic               sel_tick,
   output logic               src_valid
);
   logic [NUM_SRC-1:0] match;
   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign match[i] = (sel == SEL_W'(i + 1));
      assign hit[i]   = match[i] & tick[i];
   end

   assign sel_tick  = |hit;
   assign src_valid = |match;
endmodule

// File: rtl/fsg_phase_gen.sv
module fsg_phase_gen #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic             tick,
   input  logic [CNT_W-1:0] hi_len,
   input  logic [CNT_W-1:0] lo_len,
   output logic             fsync,
   output logic             frame_start
);
   logic             running;
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running     <= 1'b0;
         fsync       <= 1'b0;
         frame_start <= 1'b0;
         remain      <= '0;
      end else begin
         frame_start <= 1'b0;
         if (!run_req) begin
            running <= 1'b0;
            fsync   <= 1'b0;
            remain  <= '0;
         end else if (tick) begin
            if (!running) begin
               running     <= 1'b1;
               fsync       <= 1'b1;
               remain      <= hi_len;
               frame_start <= 1'b1;
            end else if (remain == '0) begin
               fsync       <= ~fsync;
               remain      <= fsync ? lo_len : hi_len;
               frame_start <= ~fsync;
            end else begin
               remain <= remain - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
   import fsg_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int DATA_W  = 12,
   parameter int CNT_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] bclk_tick,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [1:0]         rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic               fsync,
   output logic               frame_start
);
   localparam int MAX_SRC = (1 << SEL_W) - 1;

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("frame_sync_gen: NUM_SRC must be in 1..15");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("frame_sync_gen: CNT_W must be in 1..DATA_W");
   end
   if (DATA_W < SEL_W) begin : g_bad_data
      $error("frame_sync_gen: DATA_W too narrow for select field");
   end

   logic             ctl_en;
   logic [SEL_W-1:0] ctl_sel;
   logic [CNT_W-1:0] hi_len;
   logic [CNT_W-1:0] lo_len;
   logic             sel_tick;
   logic             src_valid;

   fsg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .ctl_en  (ctl_en),
      .ctl_sel (ctl_sel),
      .hi_len  (hi_len),
      .lo_len  (lo_len)
   );

   fsg_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
      .sel       (ctl_sel),
      .tick      (bclk_tick),
      .sel_tick  (sel_tick),
      .src_valid (src_valid)
   );

   fsg_phase_gen #(.CNT_W(CNT_W)) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_req     (ctl_en & src_valid),
      .tick        (sel_tick),
      .hi_len      (hi_len),
      .lo_len      (lo_len),
      .fsync       (fsync),
      .frame_start (frame_start)
   );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic src_valid,
   input logic sel_tick,
   input logic fsync,
   input logic frame_start
);
   // R5: strobe only on a rising sync edge
   a_r5_strobe_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (fsync && !$past(fsync)));

   // R5: every rising sync edge carries the strobe
   a_r5_rise_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> frame_start);

   // R7: no source selected keeps the output low
   a_r7_no_source_low: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid |=> !fsync);

   // R8 / R10: disabled generator keeps the output low
   a_r8_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !fsync);

   // R6 / R3: output moves only on a selected tick while running
   a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en && src_valid && !sel_tick) |=> $stable(fsync));
endmodule

bind frame_sync_gen fsg_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (ctl_en),
   .src_valid   (src_valid),
   .sel_tick    (sel_tick),
   .fsync       (fsync),
   .frame_start (frame_start)
);

// File: tb/frame_sync_gen_bench.sv
`timescale 1ns/100ps
module frame_sync_gen_bench;
   localparam int NUM_SRC = 4;
   localparam int DATA_W  = 12;
   localparam int CNT_W   = 12;
   localparam int LIMIT   = 150000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_SRC-1:0] bclk_tick = '0;
   logic               wr_en = 1'b0;
   logic [1:0]         wr_addr = '0;
   logic [DATA_W-1:0]  wr_data = '0;
   logic [1:0]         rd_addr = '0;
   logic [DATA_W-1:0]  rd_data;
   logic               fsync;
   logic               frame_start;

   always #2.5 clk = ~clk;

   frame_sync_gen #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame_sync_gen (
      .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .fsync(fsync), .frame_start(frame_start)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench-side tracking of expected phase lengths
   bit trk_on  = 0;
   bit started = 0;
   bit prev_fs = 0;
   int tcnt    = 0;
   int exp_len = 0;
   int m_hi    = 0;
   int m_lo    = 0;
   int b_src   = 0;
   int rises   = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int phase_len(input bit high);
      return (high ? m_hi : m_lo) + 1;
   endfunction

   task automatic step(input logic [NUM_SRC-1:0] tk, input bit wr, input logic [1:0] a,
                       input logic [DATA_W-1:0] d);
      @(negedge clk);
      bclk_tick = tk;
      wr_en     = wr;
      wr_addr   = a;
      wr_data   = d;
      @(posedge clk);
      #1;
      if (trk_on) begin
         if (fsync != prev_fs) begin
            chk(tk[b_src] == 1'b1, "R6 change without selected tick", int'(tk[b_src]), 1);
            if (started)
               chk(tcnt == exp_len, prev_fs ? "R3/R9 high phase length" : "R3/R9 low phase length",
                   tcnt, exp_len);
            else
               chk(fsync == 1'b1, "R4 first phase is high", int'(fsync), 1);
            started = 1;
            exp_len = phase_len(fsync);
            tcnt    = 1;
         end else if (tk[b_src]) begin
            tcnt++;
         end
         if (frame_start || (fsync && !prev_fs)) begin
            chk(frame_start == (fsync && !prev_fs), "R5 strobe on rise", int'(frame_start),
                int'(fsync && !prev_fs));
            if (frame_start) rises++;
         end
         prev_fs = fsync;
      end
      if (wr && a == 2'd2) m_hi = int'(d);
      if (wr && a == 2'd3) m_lo = int'(d);
   endtask

   task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
      step('0, 1'b1, a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step('0, 1'b0, 2'd0, '0);
   endtask

   task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
      @(negedge clk);
      wr_en = 1'b0;
      rd_addr = a;
      #1;
      chk(int'(rd_data) == exp, req, int'(rd_data), exp);
   endtask

   task automatic trk_start(input int src);
      b_src = src; started = 0; prev_fs = 0; tcnt = 0; rises = 0; trk_on = 1;
   endtask

   // random run on one source with noise on the others
   task automatic run_rand(input int src, input int hi, input int lo, input int n, input int dens,
                           input bit wr_mid);
      logic [NUM_SRC-1:0] tk;
      wr(2'd1, DATA_W'(src + 1));
      wr(2'd2, DATA_W'(hi));
      wr(2'd3, DATA_W'(lo));
      trk_start(src);
      wr(2'd0, 1);
      for (int i = 0; i < n; i++) begin
         if (wr_mid && ($urandom % 30) == 0) begin
            wr((($urandom % 2) == 0) ? 2'd2 : 2'd3, DATA_W'($urandom % 6));
         end else begin
            tk = NUM_SRC'($urandom);
            tk[src] = (($urandom % 100) < dens);
            step(tk, 1'b0, 2'd0, '0);
         end
      end
      chk(rises >= 2, "R3 frames produced", rises, 2);
      trk_on = 0;
      wr(2'd0, 0);
      step('1, 1'b0, 2'd0, '0);
      chk(fsync == 1'b0 && frame_start == 1'b0, "R8 low after disable", int'(fsync), 0);
   endtask

   initial begin
      bit bad;
      void'($urandom(32'd20250611));
      #12;
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(fsync == 1'b0, "R1 fsync reset", int'(fsync), 0);
      chk(frame_start == 1'b0, "R1 frame_start reset", int'(frame_start), 0);
      for (int a = 0; a < 4; a++) rd_chk(2'(a), 0, "R1 register reset");

      // R2 readback and field masking
      wr(2'd0, 12'hFFF);
      wr(2'd1, 12'hFFB);
      wr(2'd2, 12'hA5C);
      wr(2'd3, 12'h3C1);
      rd_chk(2'd0, 1, "R2 control field");
      rd_chk(2'd1, 'hB, "R2 select field");
      rd_chk(2'd2, 'hA5C, "R2 high field");
      rd_chk(2'd3, 'h3C1, "R2 low field");
      wr(2'd0, 0);
      rd_chk(2'd0, 0, "R2 control cleared");

      // R10 ticks while disabled
      wr(2'd1, 1); wr(2'd2, 1); wr(2'd3, 1);
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         step('1, 1'b0, 2'd0, '0);
         if (fsync || frame_start) bad = 1;
      end
      chk(!bad, "R10 disabled ignores ticks", int'(bad), 0);

      // R7 select 0 and out of range
      for (int s = 0; s < 2; s++) begin
         wr(2'd1, (s == 0) ? 0 : NUM_SRC + 1);
         wr(2'd0, 1);
         bad = 0;
         for (int i = 0; i < 30; i++) begin
            step('1, 1'b0, 2'd0, '0);
            if (fsync || frame_start) bad = 1;
         end
         chk(!bad, "R7 no source stays low", int'(bad), 0);
         wr(2'd0, 0);
      end

      // R6 only unselected sources tick
      wr(2'd1, 3);
      wr(2'd0, 1);
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         step(4'b1011, 1'b0, 2'd0, '0);
         if (fsync) bad = 1;
      end
      chk(!bad, "R6 other sources ignored", int'(bad), 0);
      // R4 first selected tick raises fsync
      idle(3);
      chk(fsync == 1'b0, "R4 low before tick", int'(fsync), 0);
      step(4'b0100, 1'b0, 2'd0, '0);
      chk(fsync == 1'b1 && frame_start == 1'b1, "R4 rise on first tick", int'(fsync), 1);
      wr(2'd0, 0);
      idle(1);

      // R8 disable mid high phase, then restart
      wr(2'd1, 1); wr(2'd2, 20); wr(2'd3, 20);
      wr(2'd0, 1);
      for (int i = 0; i < 5; i++) step(4'b0001, 1'b0, 2'd0, '0);
      chk(fsync == 1'b1, "R8 high before disable", int'(fsync), 1);
      wr(2'd0, 0);
      step(4'b0001, 1'b0, 2'd0, '0);
      chk(fsync == 1'b0, "R8 low after disable", int'(fsync), 0);
      trk_start(0);
      wr(2'd0, 1);
      for (int i = 0; i < 90; i++) step(4'b0001, 1'b0, 2'd0, '0);
      trk_on = 0;
      wr(2'd0, 0);
      idle(1);

      // R9 directed: shorten high mid-phase, ticks every cycle
      wr(2'd2, 5); wr(2'd3, 5);
      trk_start(0);
      wr(2'd0, 1);
      step(4'b0001, 1'b0, 2'd0, '0);
      step(4'b0001, 1'b0, 2'd0, '0);
      wr(2'd2, 1);
      for (int i = 0; i < 40; i++) step(4'b0001, 1'b0, 2'd0, '0);
      chk(rises >= 4, "R9 frames after mid-phase write", rises, 4);
      trk_on = 0;
      wr(2'd0, 0);
      idle(1);

      // odd frame R=7: high 7/2-1=2, low 8/2-1=3; and one-tick phases
      run_rand(1, 2, 3, 300, 100, 0);
      run_rand(2, 0, 0, 200, 100, 0);

      // random runs with mid-phase writes
      for (int r = 0; r < 12; r++)
         run_rand(int'($urandom % NUM_SRC), int'($urandom % 8), int'($urandom % 8), 1500,
                  20 + int'($urandom % 80), 1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule